// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage In-Order Pipeline

This block follows every instruction in a five-stage in-order pipeline (fetch, decode, execute, memory, retire) and carries a small fault record beside it. A stage that detects a problem does not act on it. It only sets a bit in the record of the instruction it currently holds. The record travels with the instruction and is examined once, when the instruction reaches the retire stage.

At retirement a clean instruction is allowed to commit. An instruction whose record has any bit set is blocked from committing. In that same cycle the block drops every younger instruction, including the one being fetched, and reports the fault code and the faulting PC. It also steers the fetch PC to a handler entry chosen by the code. Because faults are judged only at the retire stage, the oldest faulting instruction always wins, whatever order the faults were detected in.

The surrounding core uses `fetch_pc` as its fetch address and drives `fetch_valid` when it fetches. It feeds the per-stage fault inputs for whichever instruction sits in each stage, and gates its architectural writes with `retire_commit`.

Top module: `exc_precise_pipe`

## Requirements
- R1: After a synchronous active-low reset, `fetch_pc` equals RESET_PC (default 0x0000_1000), all stages are empty, and `retire_commit` and `trap_take` are both 0.
- R2: In a cycle with no trap, `fetch_pc` rises by 4 on the next edge when `fetch_valid` is 1 and holds when it is 0.
- R3: An instruction fetched at edge k reaches the retire stage after four edges. If its record is clear and no older trap removed it, `retire_commit` is 1 for one cycle and `retire_pc` shows its fetch address.
- R4: The fault record is 8 bits. Bits 0..2 come from `fetch_cause[2:0]` (instruction page fault, misaligned fetch, fetch protection). Bit 3 comes from `dec_illegal`. Bit 4 comes from `exe_arith`. Bits 5..7 come from `mem_cause[2:0]` (data page fault, misaligned data access, data protection). Each stage ORs its bits into the record of the instruction it holds, and bits are never cleared while the instruction is in flight.
- R5: When the retiring instruction has any record bit set, `trap_take` is 1, `retire_commit` is 0, and `trap_pc` shows that instruction's fetch address.
- R6: `trap_code` is the index of the lowest set bit of the retiring record.
- R7: In a trap cycle every instruction in decode, execute and memory is discarded, and so is the instruction presented at fetch. None of them later commits or traps.
- R8: On the edge after a trap, `fetch_pc` equals HANDLER_BASE (default 0x0000_0100) plus 4 times `trap_code`.
- R9: A fault input for a stage that holds no instruction has no effect. An empty stage carries a clear record and never produces a trap.
- R10: When an older instruction faults in the memory stage while a younger one has already faulted at fetch, the older one's trap is the one taken and the younger one is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | An instruction is fetched at `fetch_pc` this cycle |
| fetch_cause | input | 3 | Fetch-stage faults of the fetched instruction (record bits 0..2) |
| dec_illegal | input | 1 | Illegal opcode for the decode-stage instruction (bit 3) |
| exe_arith | input | 1 | Arithmetic fault for the execute-stage instruction (bit 4) |
| mem_cause | input | 3 | Memory-stage faults of the memory-stage instruction (bits 5..7) |
| fetch_pc | output | PC_W | Address to fetch from |
| retire_commit | output | 1 | Retiring instruction may update architectural state |
| retire_pc | output | PC_W | Fetch address of the retiring instruction |
| trap_take | output | 1 | Retiring instruction faults; younger work is flushed |
| trap_code | output | CODE_W | Lowest set bit of the retiring record |
| trap_pc | output | PC_W | Fetch address of the faulting instruction |

## Verification
The interesting collision is a trap at retirement that falls in the same cycle as a new fetch, a decode or execute fault, and an earlier fetch fault on a younger instruction still in flight. The bench provokes it by fetching back to back, with gaps, while a repeating fault plan marks some instructions with memory faults and their immediate successors with fetch faults. A scoreboard model of stage occupancy predicts which instruction retires and whether it commits or traps. It then judges each cycle by the reported PC, the code and the redirected fetch address. An isolated sweep of all 256 record patterns checks the lowest-bit code, and the bench drives all-ones garbage on every empty stage's fault input.

// File: rtl/exc_pkg.sv
// Package: shared constants for the precise exception tracker.
// Assumes a fixed 8-bit fault record with one bit per cause.
package exc_pkg;
    localparam int CAUSE_W   = 8;
    localparam int CODE_W    = $clog2(CAUSE_W);
    localparam int NUM_REG   = 4;   // decode, execute, memory, retire registers

    // Record bit positions; lower index wins when several are set.
    localparam int B_IF_PAGE   = 0;
    localparam int B_IF_ALIGN  = 1;
    localparam int B_IF_PROT   = 2;
    localparam int B_ID_ILL    = 3;
    localparam int B_EX_ARITH  = 4;
    localparam int B_MEM_PAGE  = 5;
    localparam int B_MEM_ALIGN = 6;
    localparam int B_MEM_PROT  = 7;

    typedef logic [CAUSE_W-1:0] cause_vec_t;
endpackage

// File: rtl/exc_stage_reg.sv
// Module: one pipeline register holding valid, PC and fault record.
// Merges the faults of the stage it is fed from; empty slots stay clean.
// Assumes flush has priority over any incoming instruction.
module exc_stage_reg
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            in_valid,
    input  logic [PC_W-1:0] in_pc,
    input  cause_vec_t      in_status,
    input  cause_vec_t      inject,
    output logic            out_valid,
    output logic [PC_W-1:0] out_pc,
    output cause_vec_t      out_status
);

    // Purpose: advance one slot, OR in this stage's faults, drop on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_pc     <= '0;
            out_status <= '0;
        end else if (flush) begin
            out_valid  <= 1'b0;
            out_status <= '0;
        end else begin
            out_valid  <= in_valid;
            out_pc     <= in_pc;
            out_status <= in_valid ? (in_status | inject) : '0;
        end
    end

    AST_BUBBLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_status == '0)); // R9
    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R7
    AST_RECORD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && in_valid) |=> ((out_status & $past(in_status)) == $past(in_status))); // R4

endmodule

// File: rtl/exc_lowbit_enc.sv
// Module: lowest-set-bit encoder for the fault record.
// Assumes code is meaningless when any is low.
module exc_lowbit_enc #(
    parameter int W   = 8,
    localparam int CW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] code,
    output logic          any
);

    // Purpose: scan from the top so the lowest set index is left last.
    always_comb begin
        code = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) code = CW'(i);
        end
        any = |vec;
    end

    // Purpose: the chosen bit is set and nothing below it is.
    always_comb begin
        if (any) begin
            AST_CODE_LOWEST: assert (vec[code] && ((vec & ((W'(1) << code) - W'(1))) == '0)); // R6
        end
    end

endmodule

// File: rtl/exc_fetch_pc.sv
// Module: fetch address register.
// Steps by 4 per accepted fetch; a redirect overrides the step.
module exc_fetch_pc #(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            redirect,
    input  logic [PC_W-1:0] redirect_pc,
    output logic [PC_W-1:0] pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    // Purpose: hold, step or jump the fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else if (redirect) begin
            pc <= redirect_pc;
        end else if (advance) begin
            pc <= pc + STEP;
        end
    end

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !redirect) |=> $stable(pc)); // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !redirect) |=> (pc == $past(pc) + STEP)); // R2

endmodule

// File: rtl/exc_precise_pipe.sv
// Module: top of the precise exception tracker.
// Carries a fault record per in-flight instruction, judges it at retire,
// blocks commit, flushes younger work and redirects fetch on a fault.
// Assumes no stalls: every valid slot advances each cycle.
module exc_precise_pipe
    import exc_pkg::*;
#(
    parameter int              PC_W         = 32,
    parameter logic [PC_W-1:0] RESET_PC     = 32'h0000_1000,
    parameter logic [PC_W-1:0] HANDLER_BASE = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [2:0]        fetch_cause,
    input  logic              dec_illegal,
    input  logic              exe_arith,
    input  logic [2:0]        mem_cause,
    output logic [PC_W-1:0]   fetch_pc,
    output logic              retire_commit,
    output logic [PC_W-1:0]   retire_pc,
    output logic              trap_take,
    output logic [CODE_W-1:0] trap_code,
    output logic [PC_W-1:0]   trap_pc
);

    logic              slot_v   [0:NUM_REG];
    logic [PC_W-1:0]   slot_pc  [0:NUM_REG];
    cause_vec_t        slot_st  [0:NUM_REG];
    cause_vec_t        inj      [0:NUM_REG-1];
    logic [CODE_W-1:0] code;
    logic              any_fault;
    logic [PC_W-1:0]   vector_pc;

    // Purpose: present the instruction at fetch as slot 0.
    always_comb begin
        slot_v[0]  = fetch_valid;
        slot_pc[0] = fetch_pc;
        slot_st[0] = '0;
    end

    // Purpose: place each stage's fault inputs on their record bits.
    always_comb begin
        for (int k = 0; k < NUM_REG; k++) inj[k] = '0;
        inj[0][B_IF_PROT:B_IF_PAGE]    = fetch_cause;
        inj[1][B_ID_ILL]               = dec_illegal;
        inj[2][B_EX_ARITH]             = exe_arith;
        inj[3][B_MEM_PROT:B_MEM_PAGE]  = mem_cause;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_REG; g++) begin : g_stage
            exc_stage_reg #(.PC_W(PC_W)) u_reg (
                .clk        (clk),
                .rst_n      (rst_n),
                .flush      (trap_take),
                .in_valid   (slot_v[g]),
                .in_pc      (slot_pc[g]),
                .in_status  (slot_st[g]),
                .inject     (inj[g]),
                .out_valid  (slot_v[g+1]),
                .out_pc     (slot_pc[g+1]),
                .out_status (slot_st[g+1])
            );
        end
    endgenerate

    exc_lowbit_enc #(.W(CAUSE_W)) u_enc (
        .vec  (slot_st[NUM_REG]),
        .code (code),
        .any  (any_fault)
    );

    // Purpose: retire decision and handler vector.
    always_comb begin
        retire_commit = slot_v[NUM_REG] && !any_fault;
        trap_take     = slot_v[NUM_REG] && any_fault;
        trap_code     = code;
        retire_pc     = slot_pc[NUM_REG];
        trap_pc       = slot_pc[NUM_REG];
        vector_pc     = HANDLER_BASE + (PC_W'(code) << 2);
    end

    exc_fetch_pc #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (fetch_valid),
        .redirect    (trap_take),
        .redirect_pc (vector_pc),
        .pc          (fetch_pc)
    );

    AST_COMMIT_XOR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retire_commit, trap_take})); // R5
    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (!slot_v[1] && !slot_v[2] && !slot_v[3] && !slot_v[4])); // R7
    AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (fetch_pc == HANDLER_BASE + (PC_W'($past(trap_code)) << 2))); // R8
    AST_RETIRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_take && slot_v[3]) |=> (slot_v[4] && slot_pc[4] == $past(slot_pc[3]))); // R3

endmodule

// File: tb/tb_exc_precise_pipe.sv
`timescale 1ns/1ps
module tb_exc_precise_pipe;
    localparam int PC_W = 32;
    localparam logic [31:0] RST_PC = 32'h0000_1000;
    localparam logic [31:0] HBASE  = 32'h0000_0100;

    logic clk = 1'b0;
    logic rst_n;
    logic fetch_valid, dec_illegal, exe_arith;
    logic [2:0] fetch_cause, mem_cause;
    logic [31:0] fetch_pc, retire_pc, trap_pc;
    logic retire_commit, trap_take;
    logic [2:0] trap_code;

    always #2.5 clk = ~clk;

    exc_precise_pipe #(.PC_W(PC_W), .RESET_PC(RST_PC), .HANDLER_BASE(HBASE)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_cause(fetch_cause),
        .dec_illegal(dec_illegal), .exe_arith(exe_arith), .mem_cause(mem_cause),
        .fetch_pc(fetch_pc), .retire_commit(retire_commit), .retire_pc(retire_pc),
        .trap_take(trap_take), .trap_code(trap_code), .trap_pc(trap_pc)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0]  plan [0:4095];
    logic [31:0] ipc  [0:4095];
    int sid = -1, sex = -1, smem = -1, swb = -1;
    int nseq = 0;
    int cyc = 0;
    logic [31:0] pc_m;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int lowbit(input logic [7:0] v);
        int r = 0;
        for (int i = 7; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] mix_plan(input int n);
        case (n % 9)
            1: return 8'h01;   // fetch page fault
            4: return 8'h40;   // older data misalign
            5: return 8'h02;   // younger fetch misalign, detected first (R10)
            7: return 8'h18;   // decode + execute, code 3
            default: return 8'h00;
        endcase
    endfunction

    // One cycle: check outputs at negedge, drive inputs, update model after posedge.
    task automatic step(input bit phase1);
        bit exp_trap, exp_commit, do_f;
        exp_trap   = (swb >= 0) && (plan[swb] != 8'h00);
        exp_commit = (swb >= 0) && (plan[swb] == 8'h00);
        @(negedge clk);
        chk("R2 R8 fetch_pc", fetch_pc, pc_m);
        chk("R3 R7 retire_commit", 32'(retire_commit), 32'(exp_commit));
        chk("R5 R9 trap_take", 32'(trap_take), 32'(exp_trap));
        if (exp_commit) chk("R3 retire_pc", retire_pc, ipc[swb]);
        if (exp_trap) begin
            chk("R4 R6 trap_code", 32'(trap_code), 32'(lowbit(plan[swb])));
            chk("R5 R10 trap_pc", trap_pc, ipc[swb]);
        end
        if (phase1) do_f = (sid < 0 && sex < 0 && smem < 0 && swb < 0 && nseq < 256);
        else        do_f = (cyc % 5) != 3;
        if (do_f) begin
            plan[nseq] = phase1 ? 8'(nseq) : mix_plan(nseq);
            ipc[nseq]  = pc_m;
        end
        fetch_valid = do_f;
        fetch_cause = do_f ? plan[nseq][2:0] : 3'b111;       // R9 garbage when empty
        dec_illegal = (sid  >= 0) ? plan[sid][3]    : 1'b1;
        exe_arith   = (sex  >= 0) ? plan[sex][4]    : 1'b1;
        mem_cause   = (smem >= 0) ? plan[smem][7:5] : 3'b111;
        @(posedge clk);
        cyc++;
        if (exp_trap) begin
            pc_m = HBASE + 32'(lowbit(plan[swb])) * 4;
            sid = -1; sex = -1; smem = -1; swb = -1;
        end else begin
            swb = smem; smem = sex; sex = sid;
            sid = do_f ? nseq : -1;
            if (do_f) pc_m = pc_m + 4;
        end
        if (do_f) nseq++;
    endtask

    initial begin
        rst_n = 1'b0;
        fetch_valid = 1'b1; fetch_cause = 3'b111; dec_illegal = 1'b1;
        exe_arith = 1'b1; mem_cause = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        fetch_valid = 1'b0;
        pc_m = RST_PC;
        chk("R1 fetch_pc", fetch_pc, RST_PC);
        chk("R1 retire_commit", 32'(retire_commit), 32'd0);
        chk("R1 trap_take", 32'(trap_take), 32'd0);
        // Sweep every record pattern on an isolated instruction (R4, R6).
        while (nseq < 256 || sid >= 0 || sex >= 0 || smem >= 0 || swb >= 0) step(1'b1);
        // Overlapping traffic with faults in flight (R7, R10).
        repeat (900) step(1'b0);
        repeat (6) step(1'b0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule